// File: doc/BRIEF.md
# Dual-Mode Interval Timer

This block is a word-addressed timer with a 32-bit data path. A one-cycle `tick` strobe stands for one unit of time. Each tick adds one unit to the count, and that unit sits at bit 9 of every count and limit value. Bits 8:0 of those values are always zero.

In system mode the block is a periodic timer. The count climbs from zero. When the next tick would bring it to the programmed limit, the count returns to zero, a sticky reached flag is set and the `irq` level goes high. In user mode the same four words become a 63-bit counter. Software can stop and restart it, and it also raises `irq` when it reaches its limit.

A control state machine has three states:
- `ST_SYS`: system mode.
- `ST_USR_RUN`: user mode, counting.
- `ST_USR_HALT`: user mode, stopped.

The transitions are:
- `ST_SYS` to `ST_USR_RUN` when `user_mode` goes high.
- Either user state to `ST_SYS` when `user_mode` goes low.
- `ST_USR_RUN` to `ST_USR_HALT` on a word 3 write with bit 0 clear.
- `ST_USR_HALT` to `ST_USR_RUN` on a word 3 write with bit 0 set.

Each transition caused by `user_mode` also resets the limit, the count, the reached flag and `irq`. A change of `user_mode` takes priority over any access in the same cycle.

Top module: `interval_timer`

## Requirements
- R1: After reset, word 0 reads 0x7FFFFE00, word 1 reads 0, word 3 reads 1 and `irq` is low.
- R2: While running, every cycle with `tick` high adds 0x200 to the count. In system mode, word 1 bits 30:9 show the count.
- R3: When a tick would bring the count to or past the limit, the count becomes 0 and the reached flag (word 1 bit 31 in system mode) is set. `irq` goes high one cycle later. This repeats every limit/0x200 ticks.
- R4: In system mode, a word 0 read returns the limit (bits 30:9) and lowers `irq`.
- R5: In system mode, a word 1 read returns the current reached flag and then clears it. It does not change `irq`.
- R6: In system mode, a word 0 write loads the limit from `wdata & 0x7FFFFE00`, sets the count to 0 and lowers `irq`.
- R7: In system mode, a word 2 write loads the limit and leaves the count and `irq` unchanged.
- R8: A limit that would become zero is replaced by the maximum: 0x7FFFFE00 in system mode and 0x7FFFFFFFFFFFFE00 in user mode.
- R9: Raising `user_mode` lowers `irq`, sets the limit to the maximum, clears the count and starts counting. In user mode, word 0 reads count bits 62:32 and word 1 reads count bits 31:0.
- R10: In user mode, a word 0 write sets limit bits 62:32 from `wdata[30:0]`. A word 1 write sets limit bits 31:9 from `wdata[31:9]`. Either write clears the count and lowers `irq`.
- R11: In user mode, a word 3 write runs the counter when bit 0 is 1 and stops it when bit 0 is 0. A word 3 read returns the run state in bit 0.
- R12: Lowering `user_mode` restores the limit 0x7FFFFE00, clears the count, the reached flag and `irq`, and the timer runs.
- R13: Reads of words 4 to 7 and of word 2 return 0. Writes to words 4 to 7, and word 3 writes in system mode, change nothing.
- R14: A count-clearing write beats a tick in the same cycle. A limit hit beats a clearing read of `irq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base strobe |
| user_mode | input | 1 | 1 selects the 63-bit user counter, 0 selects system mode |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| waddr | input | 3 | Word index (byte address bits 4:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en`, otherwise 0 |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle: the count-clearing write with a tick, and the limit hit with the interrupt-acknowledging word 0 read. The bench holds `tick` high across a word 0 write and expects the count to read back as zero. It then brings the count one tick short of the limit and issues a word 0 read with `tick` high. The read must return the limit, and `irq` must be high afterwards, because the hit wins.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    parameter int BUS_W    = 32;
    parameter int TICK_LSB = 9;
    parameter int WIDE_W   = 63;
    parameter int NARROW_W = 31;
    parameter int MAP_N    = 4;
    parameter int IDX_W    = 3;

    localparam int U_W    = WIDE_W - TICK_LSB;
    localparam int N_W    = NARROW_W - TICK_LSB;
    localparam int HI_LSB = BUS_W - TICK_LSB;

    typedef enum logic [1:0] {
        ST_SYS      = 2'd0,
        ST_USR_RUN  = 2'd1,
        ST_USR_HALT = 2'd2
    } tstate_e;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
    import itmr_pkg::*;
(
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] waddr,
    output logic [MAP_N-1:0] wr_sel,
    output logic [MAP_N-1:0] rd_sel
);
    for (genvar i = 0; i < MAP_N; i++) begin : g_sel
        assign wr_sel[i] = wr_en && (waddr == IDX_W'(i));
        assign rd_sel[i] = rd_en && (waddr == IDX_W'(i));
    end
endmodule

// File: rtl/itmr_core.sv
module itmr_core
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             user_mode,
    input  logic [MAP_N-1:0] wr_sel,
    input  logic [MAP_N-1:0] rd_sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rd_val,
    output logic             irq
);
    localparam logic [U_W-1:0] LIM_WIDE   = '1;
    localparam logic [U_W-1:0] LIM_NARROW = {{(U_W-N_W){1'b0}}, {N_W{1'b1}}};

    tstate_e        state_q, state_d;
    logic [U_W-1:0] cnt_q, lim_q, lim_new, step;
    logic           reached_q, irq_q;
    logic           in_user, mode_chg, running, lim_wr, cnt_rst, hit;

    assign in_user  = (state_q != ST_SYS);
    assign mode_chg = user_mode ^ in_user;
    assign running  = (state_q != ST_USR_HALT);
    assign lim_wr   = in_user ? (wr_sel[0] | wr_sel[1]) : (wr_sel[0] | wr_sel[2]);
    assign cnt_rst  = in_user ? (wr_sel[0] | wr_sel[1]) : wr_sel[0];
    assign step     = cnt_q + 1'b1;
    assign hit      = tick && running && (step >= lim_q) && !cnt_rst;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYS:      if (user_mode) state_d = ST_USR_RUN;
            ST_USR_RUN:  if (!user_mode) state_d = ST_SYS;
                         else if (wr_sel[3] && !wdata[0]) state_d = ST_USR_HALT;
            ST_USR_HALT: if (!user_mode) state_d = ST_SYS;
                         else if (wr_sel[3] && wdata[0]) state_d = ST_USR_RUN;
            default:     state_d = ST_SYS;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SYS;
        else        state_q <= state_d;
    end

    // limit value a write would load, with zero substitution
    always_comb begin
        lim_new = lim_q;
        if (!in_user) begin
            lim_new = {{(U_W-N_W){1'b0}}, wdata[NARROW_W-1:TICK_LSB]};
        end else begin
            if (wr_sel[0]) lim_new[U_W-1:HI_LSB] = wdata[U_W-HI_LSB-1:0];
            if (wr_sel[1]) lim_new[HI_LSB-1:0]   = wdata[BUS_W-1:TICK_LSB];
        end
        if (lim_new == '0) lim_new = in_user ? LIM_WIDE : LIM_NARROW;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= LIM_NARROW;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else if (mode_chg) begin
            cnt_q     <= '0;
            lim_q     <= user_mode ? LIM_WIDE : LIM_NARROW;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (lim_wr) lim_q <= lim_new;
            if (cnt_rst)                  cnt_q <= '0;
            else if (tick && running)     cnt_q <= hit ? '0 : step;
            if (hit)                      reached_q <= 1'b1;
            else if (rd_sel[1] && !in_user) reached_q <= 1'b0;
            if (hit)                      irq_q <= 1'b1;
            else if (cnt_rst || (rd_sel[0] && !in_user)) irq_q <= 1'b0;
        end
    end

    // read outputs
    always_comb begin
        rd_val = '0;
        unique case (state_q)
            ST_SYS: begin
                if (rd_sel[0])      rd_val = {1'b0, lim_q[N_W-1:0], {TICK_LSB{1'b0}}};
                else if (rd_sel[1]) rd_val = {reached_q, cnt_q[N_W-1:0], {TICK_LSB{1'b0}}};
                else if (rd_sel[3]) rd_val = {{(BUS_W-1){1'b0}}, 1'b1};
            end
            ST_USR_RUN, ST_USR_HALT: begin
                if (rd_sel[0])      rd_val = {1'b0, cnt_q[U_W-1:HI_LSB]};
                else if (rd_sel[1]) rd_val = {cnt_q[HI_LSB-1:0], {TICK_LSB{1'b0}}};
                else if (rd_sel[3]) rd_val = {{(BUS_W-1){1'b0}}, running};
            end
            default: rd_val = '0;
        endcase
    end

    assign irq = irq_q;

    // R3: interrupt only rises after a tick
    assert_irq_from_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(tick));
    // R8: the limit never holds zero
    assert_lim_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lim_q != '0);
    // R11: a stopped counter keeps its value
    assert_halt_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USR_HALT && user_mode && !wr_sel[0] && !wr_sel[1]) |=> $stable(cnt_q));
    // R9: entering user mode clears interrupt and count
    assert_user_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYS && user_mode) |=> (!irq_q && cnt_q == '0 && state_q == ST_USR_RUN));
    // R12: leaving user mode restores the narrow limit
    assert_sys_return_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SYS && !user_mode) |=> (!irq_q && lim_q == LIM_NARROW && !reached_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             user_mode,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] waddr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq
);
    logic [MAP_N-1:0] wr_sel, rd_sel;
    logic [BUS_W-1:0] rd_val;

    itmr_decode u_decode (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .waddr  (waddr),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    itmr_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .user_mode (user_mode),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel),
        .wdata     (wdata),
        .rd_val    (rd_val),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
        else            rdata <= '0;
    end

    // R13: unmapped reads return zero
    assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && waddr >= IDX_W'(MAP_N)) |=> (rdata == '0));
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        user_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  waddr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
        .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        waddr = a; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        waddr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // monitor: pops expected read data and compares
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                check(rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({31'b0, irq}, 0, "R1 irq after reset");
        rd(3'd0, 32'h7FFFFE00, "R1 limit after reset");
        rd(3'd1, 32'h0, "R1 count after reset");
        rd(3'd3, 32'h1, "R1 run state after reset");

        pulse(3);
        rd(3'd1, 32'h600, "R2 count after 3 ticks");

        wr(3'd0, 32'h80000A55);
        rd(3'd0, 32'hA00, "R6 masked limit");
        rd(3'd1, 32'h0, "R6 count cleared");

        pulse(4);
        check({31'b0, irq}, 0, "R3 irq before limit");
        pulse(1);
        check({31'b0, irq}, 1, "R3 irq at limit");
        rd(3'd1, 32'h80000000, "R3 reached set, count wrapped");
        rd(3'd1, 32'h0, "R5 reached cleared by read");
        check({31'b0, irq}, 1, "R5 irq kept by word 1 read");
        rd(3'd0, 32'hA00, "R4 limit read");
        check({31'b0, irq}, 0, "R4 irq acknowledged");

        pulse(5);
        check({31'b0, irq}, 1, "R3 periodic second hit");
        rd(3'd1, 32'h80000000, "R3 second reached");
        rd(3'd0, 32'hA00, "R4 second ack");

        pulse(2);
        wr(3'd2, 32'h00001400);
        rd(3'd1, 32'h400, "R7 count kept on word 2 write");
        rd(3'd0, 32'h1400, "R7 limit loaded");

        wr(3'd0, 32'h0);
        rd(3'd0, 32'h7FFFFE00, "R8 zero limit in system mode");

        tick = 1'b1;
        wr(3'd0, 32'hA00);
        tick = 1'b0;
        rd(3'd1, 32'h0, "R14 write beats tick");
        pulse(4);
        tick = 1'b1;
        rd(3'd0, 32'hA00, "R14 limit read during hit");
        tick = 1'b0;
        check({31'b0, irq}, 1, "R14 hit beats acknowledge");
        rd(3'd0, 32'hA00, "R4 ack after collision");
        check({31'b0, irq}, 0, "R4 irq low after ack");
        rd(3'd1, 32'h80000000, "R14 reached from collision hit");

        rd(3'd4, 32'h0, "R13 word 4 reads zero");
        rd(3'd2, 32'h0, "R13 word 2 reads zero");
        wr(3'd3, 32'h0);
        rd(3'd3, 32'h1, "R13 word 3 write ignored in system mode");
        wr(3'd5, 32'h12345678);
        rd(3'd0, 32'hA00, "R13 word 5 write ignored (limit)");
        rd(3'd1, 32'h0, "R13 word 5 write ignored (count)");

        pulse(5);
        check({31'b0, irq}, 1, "R3 irq before mode switch");
        user_mode = 1'b1;
        @(negedge clk);
        check({31'b0, irq}, 0, "R9 irq lowered on user entry");
        rd(3'd0, 32'h0, "R9 upper count zero");
        rd(3'd1, 32'h0, "R9 lower count zero");
        rd(3'd3, 32'h1, "R9 running after entry");
        pulse(3);
        rd(3'd1, 32'h600, "R9 lower count word");
        rd(3'd0, 32'h0, "R9 upper count word");

        wr(3'd0, 32'h0);
        wr(3'd1, 32'h600);
        pulse(2);
        check({31'b0, irq}, 0, "R10 small limit not yet hit");
        pulse(1);
        check({31'b0, irq}, 1, "R10 small limit hit");
        rd(3'd1, 32'h0, "R10 count wrapped");
        wr(3'd1, 32'h600);
        check({31'b0, irq}, 0, "R10 write lowers irq");

        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        pulse(5);
        check({31'b0, irq}, 0, "R8 zero limit in user mode");
        rd(3'd1, 32'hA00, "R8 count keeps running");

        wr(3'd3, 32'h0);
        rd(3'd3, 32'h0, "R11 stopped state");
        pulse(4);
        rd(3'd1, 32'hA00, "R11 count held while stopped");
        wr(3'd3, 32'h1);
        rd(3'd3, 32'h1, "R11 running state");
        pulse(1);
        rd(3'd1, 32'hC00, "R11 count resumes");

        user_mode = 1'b0;
        @(negedge clk);
        check({31'b0, irq}, 0, "R12 irq low after return");
        rd(3'd0, 32'h7FFFFE00, "R12 limit restored");
        rd(3'd1, 32'h0, "R12 count and reached cleared");
        rd(3'd3, 32'h1, "R12 running");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule